// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Appender

This block sits on the transmit side of a MAC, on a byte-wide stream. Each payload byte offered on the input is passed unchanged to the output one clock later. A CRC-32 over the frame is updated at the same time, one full byte per clock, so the block never stalls while a frame is in progress. A 125 MHz clock therefore carries 1 Gb/s. When the byte flagged as the end of the frame has been taken, the block appends four trailer bytes that hold the frame check sequence. During those four cycles it holds off the upstream source. It then returns to plain pass-through, ready for the next frame.

The remainder is computed with the right-shifting form of the CRC-32 polynomial. Within a byte, bit 0 is processed first. The register starts from all ones, and the trailer is the final remainder with every bit inverted. At the moment the last payload byte is taken, the finished check value moves into a separate holding register. This lets the running CRC register restart at once for a back-to-back frame while the trailer is still draining.

Top module: `fcs_appender`

## Requirements
- R1: A byte accepted on a clock edge (inValid high while inReady high) appears on outData at that same edge, with outValid high and outLast low.
- R2: The check value is computed one bit at a time, starting at bit 0 of each byte. For each bit, the feedback is register bit 0 XOR the data bit. The register shifts right by one, and 0xEDB88320 is XORed in when the feedback is 1. A byte applies eight such steps.
- R3: The CRC register holds 0xFFFFFFFF after reset and again at the start of every frame, including after a frame cut short by reset.
- R4: The four edges after the last payload byte carry the inverted final remainder (remainder XOR 0xFFFFFFFF), bits 7:0 first and bits 31:24 last, with outValid high.
- R5: inReady is low for exactly the four cycles that follow the acceptance of a byte with inLast high, and high at all other times out of reset.
- R6: outLast is high only together with the fourth trailer byte.
- R7: No cycle is lost. A new frame offered during the trailer is taken in the first cycle after it, so two back-to-back frames of 9 bytes produce 26 contiguous output bytes.
- R8: The payload 0x31..0x39 produces the trailer bytes 0x26, 0x39, 0xF4, 0xCB in that order (check value 0xCBF43926).
- R9: A frame of one payload byte produces exactly five output bytes.
- R10: While rstN is low, outValid and outLast are low and inReady is high, whatever the previous state.
- R11: In pass-through, a cycle with inValid low produces no output byte and leaves the running CRC unchanged, so idle gaps inside a frame do not alter its trailer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inData | input | 8 | Payload byte from upstream |
| inValid | input | 1 | inData holds a byte |
| inLast | input | 1 | inData is the final payload byte of the frame |
| inReady | output | 1 | Block can take a byte this cycle (low during the trailer) |
| outData | output | 8 | Payload or trailer byte |
| outValid | output | 1 | outData holds a byte |
| outLast | output | 1 | outData is the final trailer byte |

## Verification
A corrupted CRC register does not show at the ports until the trailer of the current frame. The bench compares every trailer byte with a behavioural model, so such a fault appears within four cycles of the frame's last byte. It also appears in every later frame if the restart value is wrong. A sequencer that loses count shows up in the same cycle: inReady, outValid or outLast disagrees with the model. Errors in byte order or inversion appear on the first trailer byte. Mid-frame resets, idle gaps and back-to-back frames make sure that stale state from one frame cannot hide in the next frame.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  // Strobes from the sequencer to the datapath, valid for the current cycle
  typedef struct packed {
    logic accept;    // an input byte is taken this cycle
    logic endFrame;  // the byte taken is the frame's final payload byte
    logic emit;      // a trailer byte is sent this cycle
    logic emitLast;  // the trailer byte sent is the final one
  } fcsStrobes_t;

endpackage

// File: rtl/crc_byte_update.sv
// Combinational CRC advance over one data word, least significant bit first.
module crc_byte_update #(
  parameter int CRC_W = 32,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB8_8320
) (
  input  logic [CRC_W-1:0]  crcIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CRC_W-1:0]  crcOut
);

  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = crcIn;

  // One serial step per data bit; the chain collapses into an XOR tree.
  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    logic feedback;
    assign feedback     = stage[i][0] ^ dataIn[i];
    assign stage[i + 1] = (stage[i] >> 1) ^ (feedback ? POLY : '0);
  end

  assign crcOut = stage[DATA_W];

endmodule

// File: rtl/fcs_ctrl.sv
// Sequencer: pass-through state and trailer countdown.
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int FCS_BYTES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inLast,
  output logic        inReady,
  output fcsStrobes_t strb
);

  localparam int CNT_W = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FCS_BYTES - 1);

  typedef enum logic {ST_PASS, ST_TAIL} seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] tailCnt;

  assign inReady       = (state == ST_PASS);
  assign strb.accept   = inValid && inReady;
  assign strb.endFrame = strb.accept && inLast;
  assign strb.emit     = (state == ST_TAIL);
  assign strb.emitLast = strb.emit && (tailCnt == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PASS;
      tailCnt <= '0;
    end else if (state == ST_PASS) begin
      if (strb.endFrame) begin
        state   <= ST_TAIL;
        tailCnt <= '0;
      end
    end else if (tailCnt == LAST_IDX) begin
      state   <= ST_PASS;
      tailCnt <= '0;
    end else begin
      tailCnt <= tailCnt + 1'b1;
    end
  end

  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> !inReady);

  // R5
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && tailCnt != LAST_IDX) |=> !inReady);

  // R7
  tail_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && tailCnt == LAST_IDX) |=> inReady);

endmodule

// File: rtl/fcs_datapath.sv
// Running CRC, trailer holding register and registered output stage.
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int CRC_W = 32,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB8_8320,
  parameter logic [CRC_W-1:0] INIT = 32'hFFFF_FFFF,
  parameter logic [CRC_W-1:0] XOROUT = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcsStrobes_t       strb,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outLast
);

  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcNext;
  logic [CRC_W-1:0] fcsHold;

  crc_byte_update #(
    .CRC_W (CRC_W),
    .DATA_W(DATA_W),
    .POLY  (POLY)
  ) u_crc (
    .crcIn (crcReg),
    .dataIn(inData),
    .crcOut(crcNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg   <= INIT;
      fcsHold  <= '0;
      outData  <= '0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
    end else if (strb.accept) begin
      outData  <= inData;
      outValid <= 1'b1;
      outLast  <= 1'b0;
      if (strb.endFrame) begin
        fcsHold <= crcNext ^ XOROUT;
        crcReg  <= INIT;
      end else begin
        crcReg  <= crcNext;
      end
    end else if (strb.emit) begin
      outData  <= fcsHold[DATA_W-1:0];
      fcsHold  <= fcsHold >> DATA_W;
      outValid <= 1'b1;
      outLast  <= strb.emitLast;
    end else begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
    end
  end

  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> (outValid && !outLast && outData == $past(inData)));

  // R3
  crc_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.endFrame |=> (crcReg == INIT));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.accept && !strb.emit) |=> (!outValid && $stable(crcReg)));

  // R6
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

endmodule

// File: rtl/fcs_appender.sv
// Thin top: sequencer plus datapath.
module fcs_appender
  import fcs_pkg::*;
#(
  parameter int CRC_W = 32,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB8_8320,
  parameter logic [CRC_W-1:0] INIT = 32'hFFFF_FFFF,
  parameter logic [CRC_W-1:0] XOROUT = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outLast
);

  localparam int FCS_BYTES = CRC_W / DATA_W;

  fcsStrobes_t strb;

  fcs_ctrl #(
    .FCS_BYTES(FCS_BYTES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inLast (inLast),
    .inReady(inReady),
    .strb   (strb)
  );

  fcs_datapath #(
    .CRC_W (CRC_W),
    .DATA_W(DATA_W),
    .POLY  (POLY),
    .INIT  (INIT),
    .XOROUT(XOROUT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inData  (inData),
    .outData (outData),
    .outValid(outValid),
    .outLast (outLast)
  );

endmodule

// File: tb/fcs_appender_test.sv
`timescale 1ns/1ps
module fcs_appender_test;

  localparam logic [31:0] REF_POLY = 32'hEDB8_8320;

  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady;
  logic [7:0] outData;
  logic       outValid;
  logic       outLast;

  always #2.5 clk = ~clk;

  fcs_appender uut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outData(outData), .outValid(outValid), .outLast(outLast)
  );

  int checks = 0;
  int errors = 0;
  bit checking = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural definition of the check value (R2)
  function automatic logic [31:0] refCrc(logic [31:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ REF_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction

  // Reference model, updated on every clock edge
  int         mTail;
  logic [7:0] tailQ[$];
  logic [31:0] mCrc, mFcs;
  logic       expValid, expLast, expIsTail;
  logic [7:0] expData;
  bit         mAcc;
  int         cyc = 0;

  always @(posedge clk) cyc++;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTail = 0; tailQ.delete(); mCrc = 32'hFFFF_FFFF;
      expValid = 0; expLast = 0; expIsTail = 0; expData = '0; mAcc = 0;
    end else begin
      mAcc = inValid && (mTail == 0);
      if (mAcc) begin
        expData = inData; expValid = 1; expLast = 0; expIsTail = 0;
        mCrc = refCrc(mCrc, inData);
        if (inLast) begin
          mFcs = ~mCrc;
          for (int k = 0; k < 4; k++) tailQ.push_back(mFcs[8*k +: 8]);
          mCrc = 32'hFFFF_FFFF;
          mTail = 4;
        end
      end else if (mTail > 0) begin
        expData = tailQ.pop_front(); expValid = 1; expLast = (mTail == 1);
        expIsTail = 1; mTail--;
      end else begin
        expValid = 0; expLast = 0; expIsTail = 0;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  logic [7:0] gotQ[$];
  int firstCyc = -1;
  int lastCyc = -1;

  always @(negedge clk) begin
    if (checking) begin
      check(outValid === expValid, expValid ? (expIsTail ? "R4" : "R1") : "R11",
            32'(outValid), 32'(expValid));
      check(outLast === expLast, "R6", 32'(outLast), 32'(expLast));
      check(inReady === (mTail == 0), "R5", 32'(inReady), 32'(mTail == 0));
      if (expValid)
        check(outData === expData, expIsTail ? "R2 R4" : "R1", 32'(outData), 32'(expData));
      if (outValid) begin
        gotQ.push_back(outData);
        if (firstCyc < 0) firstCyc = cyc;
      end
      if (outLast) lastCyc = cyc;
    end
  end

  task automatic sendFrame(input logic [7:0] b[$], input int gapPct, input bit withLast);
    foreach (b[i]) begin
      if (gapPct > 0 && int'($urandom % 100) < gapPct) begin
        @(negedge clk); inValid = 0; inLast = 0;
      end
      @(negedge clk);
      inValid = 1; inData = b[i]; inLast = withLast && (i == b.size() - 1);
      do begin @(posedge clk); #1; end while (!mAcc);
    end
  endtask

  task automatic waitIdle();
    @(negedge clk); inValid = 0; inLast = 0;
    repeat (8) @(negedge clk);
  endtask

  logic [7:0] digits[$] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

  initial begin
    logic [7:0] q[$];
    #3 rstN = 0;
    checking = 1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(outValid === 0 && outLast === 0, "R10", 32'(outValid), 0);
    check(inReady === 1, "R10", 32'(inReady), 1);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R8: standard check value
    gotQ.delete();
    sendFrame(digits, 0, 1);
    waitIdle();
    check(gotQ.size() == 13, "R8", gotQ.size(), 13);
    if (gotQ.size() == 13)
      check({gotQ[12], gotQ[11], gotQ[10], gotQ[9]} == 32'hCBF4_3926, "R8",
            {gotQ[12], gotQ[11], gotQ[10], gotQ[9]}, 32'hCBF4_3926);

    // R9: single-byte frame
    gotQ.delete();
    q = '{8'hA5};
    sendFrame(q, 0, 1);
    waitIdle();
    check(gotQ.size() == 5, "R9", gotQ.size(), 5);

    // R7: back-to-back frames without a lost cycle
    gotQ.delete(); firstCyc = -1; lastCyc = -1;
    sendFrame(digits, 0, 1);
    sendFrame(digits, 0, 1);
    waitIdle();
    check(gotQ.size() == 26, "R7", gotQ.size(), 26);
    check(lastCyc - firstCyc + 1 == 26, "R7", lastCyc - firstCyc + 1, 26);

    // R11: idle gaps inside frames
    for (int f = 0; f < 6; f++) begin
      q.delete();
      for (int n = 0; n < 5 + f * 3; n++) q.push_back(8'($urandom));
      sendFrame(q, 40, 1);
    end
    waitIdle();

    // R3 R10: reset in the middle of a frame, then a clean frame
    q = '{8'h12, 8'h34, 8'h56};
    sendFrame(q, 0, 0);
    @(negedge clk); inValid = 0;
    #1 rstN = 0;
    @(negedge clk);
    check(outValid === 0 && inReady === 1, "R10", {outValid, inReady}, 32'h1);
    rstN = 1;
    @(negedge clk);
    gotQ.delete();
    sendFrame(digits, 0, 1);
    waitIdle();
    if (gotQ.size() == 13)
      check({gotQ[12], gotQ[11], gotQ[10], gotQ[9]} == 32'hCBF4_3926, "R3",
            {gotQ[12], gotQ[11], gotQ[10], gotQ[9]}, 32'hCBF4_3926);
    else
      check(0, "R3", gotQ.size(), 13);

    // Random frames, mixed gaps and back-to-back runs
    for (int f = 0; f < 40; f++) begin
      q.delete();
      for (int n = 0; n < 1 + int'($urandom % 24); n++) q.push_back(8'($urandom));
      sendFrame(q, (f % 3 == 0) ? 25 : 0, 1);
      if (f % 4 == 3) waitIdle();
    end
    waitIdle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule